// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link. Through it a host reaches a bank of eight byte-wide timekeeping registers. The three wires are an active-high enable line that frames each transfer, a serial clock, and one shared data line. The block decodes a command byte and then moves data in one of two ways:

- a single byte to or from one register;
- a burst that visits every register in turn, from index 0 to index 7.

All bits travel least significant bit first.

The block runs on a system clock that is much faster than the serial clock, which can run at up to 2 MHz. All three serial wires pass through two-flop synchronizers, and an edge detector then finds the serial clock edges. The register bank stays outside the block. The block issues a one-hot write strobe with a data byte, and it issues an index that selects which register the bank returns on the read-data input. The shared data line is split into an input, an output value and an output enable.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, `dio_oe` is low, `wr_strobe` is all zero and `rd_sel` is 0.
- R2: The first byte after the enable line rises is a command, received LSB first on serial clock rising edges. Command fields:
  - bit 0: 1 for read, 0 for write;
  - bits 5:1: register address;
  - bits 7:6: ignored.
- R3: A single write to address 0..7 gives exactly one `wr_strobe` pulse, one system cycle long, with only that register's bit set. `wr_data` carries the data byte, assembled LSB first. The pulse comes only after the eighth data bit has been sampled.
- R4: A single read from address 0..7 drives the register value LSB first, with one bit after each falling edge of the serial clock. The first bit follows the falling edge that ends the command byte, and `dio_oe` is high for these 8 bits. The ninth falling edge releases `dio_oe`.
- R5: A write command to address 31 (burst) writes 8 consecutive bytes into registers 0, 1, … 7 in that order, one strobe per byte.
- R6: A read command to address 31 drives 64 bits: registers 0 through 7, in order, each byte LSB first.
- R7: Once a transfer is finished, further serial clocks in the same enable window give no strobe and no drive. This includes the point after index 7 of a burst.
- R8: Dropping the enable line aborts the transfer:
  - `dio_oe` falls at once;
  - a partly received byte is discarded;
  - the next enable window starts again with a command byte.
- R9: A command whose address is neither below 8 nor 31 gives no strobe and no drive for the rest of the window.
- R10: The data line is driven only during read data phases. It is never driven during the command byte or during write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Transfer enable line from the host; low resets the serial state |
| ser_clk | input | 1 | Serial clock from the host |
| dio_in | input | 1 | Value seen on the shared data line |
| dio_out | output | 1 | Bit the block places on the data line |
| dio_oe | output | 1 | Output enable for the data line driver |
| wr_strobe | output | 8 | One-hot register write strobe, one cycle wide |
| wr_data | output | 8 | Byte to write, valid while a strobe is high |
| rd_sel | output | 3 | Index of the register the bank must present on `rd_data` |
| rd_data | input | 8 | Contents of the selected register |

## Verification
A serial edge reaches the outputs on the third system clock edge after it:

- two edges pass through the synchronizer;
- one edge registers the result.

So a strobe follows a rising edge, and a new data bit follows a falling edge, by three cycles. The bench holds each serial half period for eight system clocks. It samples `dio_out` and `dio_oe` on a falling system clock edge just before it raises the serial clock, so every read bit has settled. It checks strobe counts and the bank contents only after the enable line has dropped. The one result with no such delay is the release of `dio_oe` on an abort, and the bench checks it 1 ns after it lowers the enable line.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } srp_phase_e;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/srp_edge.sv
module srp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/srp_shift_in.sv
module srp_shift_in #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sample,
  input  logic          din,
  output logic          done,
  output logic [DW-1:0] value
);

  localparam int CNT_W = $clog2(DW);

  logic [DW-2:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_bit;

  assign last_bit = (int'(cnt_q) == DW-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (sample) begin
      sh_q  <= {din, sh_q[DW-2:1]};
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end

  // LSB-first: newest bit lands on top, earlier bits below it
  assign done  = sample && last_bit;
  assign value = {din, sh_q};

endmodule

// File: rtl/srp_shift_out.sv
module srp_shift_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] par_in,
  output logic          bit_out,
  output logic          at_start
);

  localparam int CNT_W = $clog2(DW);

  logic [DW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (load) begin
      bit_q <= par_in[0];
      sh_q  <= par_in >> 1;
      cnt_q <= CNT_W'(1);
    end else if (shift) begin
      bit_q <= sh_q[0];
      sh_q  <= sh_q >> 1;
      cnt_q <= (int'(cnt_q) == DW-1) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_out  = bit_q;
  assign at_start = (cnt_q == '0);

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int DW          = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_en,
  input  logic                     ser_clk,
  input  logic                     dio_in,
  output logic                     dio_out,
  output logic                     dio_oe,
  output logic [NREG-1:0]          wr_strobe,
  output logic [DW-1:0]            wr_data,
  output logic [$clog2(NREG)-1:0]  rd_sel,
  input  logic [DW-1:0]            rd_data
);

  localparam int IDX_W      = $clog2(NREG);
  localparam int BURST_ADDR = (1 << ADDR_W) - 1;

  // ---------------- command arithmetic ----------------
  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [DW-1:0] c);
    return c[ADDR_W:1];
  endfunction

  function automatic logic cmd_read(input logic [DW-1:0] c);
    return c[0];
  endfunction

  function automatic logic addr_burst(input logic [ADDR_W-1:0] a);
    return a == ADDR_W'(BURST_ADDR);
  endfunction

  function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
    return addr_burst(a) || (int'(a) < NREG);
  endfunction

  function automatic logic idx_last(input logic [IDX_W-1:0] i, input logic burst);
    return !burst || (int'(i) == NREG-1);
  endfunction

  // ---------------- synchronizers and edges ----------------
  logic [2:0] raw_in, sync_lvl;
  logic       en_s, sclk_s, din_s;
  logic       rise_ev, fall_ev;

  assign raw_in = {dio_in, ser_clk, ser_en};

  srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_lvl)
  );

  assign en_s   = sync_lvl[0];
  assign sclk_s = sync_lvl[1];
  assign din_s  = sync_lvl[2];

  srp_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sclk_s),
    .rise (rise_ev),
    .fall (fall_ev)
  );

  // ---------------- state ----------------
  srp_phase_e        phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic              burst_q;
  logic              fin_q;
  logic              drive_q;
  logic [NREG-1:0]   wr_strobe_q;
  logic [DW-1:0]     wr_data_q;

  // ---------------- receive path ----------------
  logic          rx_sample, rx_clr, rx_done;
  logic [DW-1:0] rx_value;

  assign rx_clr    = !en_s;
  assign rx_sample = en_s && rise_ev && (phase_q == PH_CMD || phase_q == PH_WR);

  srp_shift_in #(.DW(DW)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .sample(rx_sample),
    .din   (din_s),
    .done  (rx_done),
    .value (rx_value)
  );

  // named events for the checker
  logic              cmd_done, byte_wr, cmd_bad;
  logic [ADDR_W-1:0] cmd_a;
  logic              cmd_is_burst;

  assign cmd_a        = cmd_addr(rx_value);
  assign cmd_is_burst = addr_burst(cmd_a);
  assign cmd_done     = rx_done && (phase_q == PH_CMD);
  assign byte_wr      = rx_done && (phase_q == PH_WR);
  assign cmd_bad      = cmd_done && !addr_ok(cmd_a);

  // ---------------- transmit path ----------------
  logic rd_fall, tx_at_start, tx_load, tx_shift, rd_end, tx_clr;

  assign tx_clr   = !en_s;
  assign rd_fall  = en_s && fall_ev && (phase_q == PH_RD);
  assign tx_load  = rd_fall && tx_at_start && !fin_q;
  assign tx_shift = rd_fall && !tx_at_start;
  assign rd_end   = rd_fall && tx_at_start && fin_q;

  srp_shift_out #(.DW(DW)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tx_clr),
    .load    (tx_load),
    .shift   (tx_shift),
    .par_in  (rd_data),
    .bit_out (dio_out),
    .at_start(tx_at_start)
  );

  // ---------------- transfer sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_CMD;
      idx_q       <= '0;
      burst_q     <= 1'b0;
      fin_q       <= 1'b0;
      drive_q     <= 1'b0;
      wr_strobe_q <= '0;
      wr_data_q   <= '0;
    end else if (!en_s) begin
      phase_q     <= PH_CMD;
      idx_q       <= '0;
      burst_q     <= 1'b0;
      fin_q       <= 1'b0;
      drive_q     <= 1'b0;
      wr_strobe_q <= '0;
    end else begin
      wr_strobe_q <= '0;
      if (cmd_done) begin
        if (!addr_ok(cmd_a)) begin
          phase_q <= PH_DONE;
        end else begin
          phase_q <= cmd_read(rx_value) ? PH_RD : PH_WR;
          burst_q <= cmd_is_burst;
          idx_q   <= cmd_is_burst ? '0 : cmd_a[IDX_W-1:0];
          fin_q   <= 1'b0;
        end
      end
      if (byte_wr) begin
        wr_strobe_q <= {{(NREG-1){1'b0}}, 1'b1} << idx_q;
        wr_data_q   <= rx_value;
        if (idx_last(idx_q, burst_q)) phase_q <= PH_DONE;
        else                          idx_q   <= idx_q + 1'b1;
      end
      if (tx_load) begin
        drive_q <= 1'b1;
        fin_q   <= idx_last(idx_q, burst_q);
        if (!idx_last(idx_q, burst_q)) idx_q <= idx_q + 1'b1;
      end
      if (rd_end) begin
        drive_q <= 1'b0;
        phase_q <= PH_DONE;
      end
    end
  end

  assign wr_strobe = wr_strobe_q;
  assign wr_data   = wr_data_q;
  assign rd_sel    = idx_q;
  assign dio_oe    = drive_q & ser_en;

endmodule

// File: rtl/srp_checker.sv
module srp_checker
  import srp_pkg::*;
#(
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_s,
  input logic            rise_ev,
  input logic            fall_ev,
  input logic            cmd_bad,
  input srp_phase_e      phase,
  input logic            drive,
  input logic [NREG-1:0] wr_strobe
);

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));

  // R3
  strobe_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_strobe) |-> $past(rise_ev));

  // R10
  strobe_not_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_strobe) |-> !drive);

  // R4
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(fall_ev));

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!drive && wr_strobe == '0));

  // R9
  bad_cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> phase == PH_DONE);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && en_s) |=> phase == PH_DONE);

endmodule

bind serial_reg_port srp_checker #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_s     (en_s),
  .rise_ev  (rise_ev),
  .fall_ev  (fall_ev),
  .cmd_bad  (cmd_bad),
  .phase    (phase_q),
  .drive    (drive_q),
  .wr_strobe(wr_strobe)
);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 8;
  localparam int NREG       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_en = 1'b0;
  logic       ser_clk = 1'b0;
  logic       host_d = 1'b0;
  logic       dio_out, dio_oe;
  logic [7:0] wr_strobe;
  logic [7:0] wr_data;
  logic [2:0] rd_sel;
  logic [7:0] rd_data;

  logic [7:0] bank     [NREG];
  logic [7:0] exp_bank [NREG];
  int strobes = 0;
  int checks  = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_port u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en   (ser_en),
    .ser_clk  (ser_clk),
    .dio_in   (host_d),
    .dio_out  (dio_out),
    .dio_oe   (dio_oe),
    .wr_strobe(wr_strobe),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
  );

  // register bank model on the far side of the port
  initial for (int i = 0; i < NREG; i++) begin
    bank[i]     = 8'h10 + 8'(i);
    exp_bank[i] = 8'h10 + 8'(i);
  end

  always @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (wr_strobe[i]) begin
        bank[i] <= wr_data;
        strobes++;
      end
    end
  end

  assign rd_data = bank[rd_sel];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic logic [7:0] mk_cmd(input int addr, input bit rd, input logic [1:0] hi);
    return {hi, 5'(addr), rd};
  endfunction

  task automatic clk_bit(input logic b, output logic got, output logic got_oe);
    @(negedge clk) host_d = b;
    repeat (HP) @(negedge clk);
    got    = dio_out;
    got_oe = dio_oe;
    ser_clk = 1'b1;
    repeat (HP) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic begin_xfer();
    @(negedge clk) ser_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_xfer();
    repeat (HP) @(negedge clk);
    ser_en = 1'b0;
    #1;
    // R8 release of the driver is immediate
    chk(dio_oe == 1'b0, "R8 oe at enable drop", int'(dio_oe), 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic g, o;
    for (int i = 0; i < 8; i++) begin
      clk_bit(c[i], g, o);
      chk(o == 1'b0, "R10 no drive during command", int'(o), 0);
    end
  endtask

  task automatic single_write(input int addr, input logic [7:0] v, input logic [1:0] hi,
                              input string tag);
    logic g, o;
    int s0, expn;
    s0 = strobes;
    begin_xfer();
    send_cmd(mk_cmd(addr, 1'b0, hi));
    for (int i = 0; i < 8; i++) begin
      clk_bit(v[i], g, o);
      chk(o == 1'b0, "R10 no drive during write data", int'(o), 0);
    end
    end_xfer();
    expn = (addr < NREG) ? 1 : 0;
    if (addr < NREG) exp_bank[addr] = v;
    chk(strobes - s0 == expn, tag, strobes - s0, expn);
    for (int i = 0; i < NREG; i++)
      chk(bank[i] == exp_bank[i], tag, int'(bank[i]), int'(exp_bank[i]));
  endtask

  task automatic single_read(input int addr, input logic [1:0] hi, input string tag);
    logic g, o;
    logic [7:0] got;
    bit valid;
    valid = (addr < NREG);
    begin_xfer();
    send_cmd(mk_cmd(addr, 1'b1, hi));
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b0, g, o);
      got[i] = g;
      chk(o == valid, tag, int'(o), int'(valid));
    end
    clk_bit(1'b0, g, o);
    // R4 driver released after the eighth bit
    chk(o == 1'b0, "R4 release after byte", int'(o), 0);
    end_xfer();
    if (valid) chk(got == exp_bank[addr], tag, int'(got), int'(exp_bank[addr]));
  endtask

  task automatic burst_write(input logic [63:0] vals);
    logic g, o;
    int s0;
    s0 = strobes;
    begin_xfer();
    send_cmd(mk_cmd(31, 1'b0, 2'b00));
    for (int i = 0; i < 64; i++) begin
      clk_bit(vals[i], g, o);
      chk(o == 1'b0, "R10 no drive in burst write", int'(o), 0);
    end
    repeat (6) @(negedge clk);
    chk(strobes - s0 == 8, "R5 burst strobe count", strobes - s0, 8);
    // R7 clocks past index 7 have no effect
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b1, g, o);
      chk(o == 1'b0, "R7 no drive after burst", int'(o), 0);
    end
    end_xfer();
    chk(strobes - s0 == 8, "R7 no strobe after burst", strobes - s0, 8);
    for (int i = 0; i < NREG; i++) begin
      exp_bank[i] = vals[8*i +: 8];
      chk(bank[i] == exp_bank[i], "R5 burst write contents", int'(bank[i]), int'(exp_bank[i]));
    end
  endtask

  task automatic burst_read();
    logic g, o;
    logic [63:0] got;
    begin_xfer();
    send_cmd(mk_cmd(31, 1'b1, 2'b00));
    for (int i = 0; i < 64; i++) begin
      clk_bit(1'b0, g, o);
      got[i] = g;
      chk(o == 1'b1, "R6 drive during burst read", int'(o), 1);
    end
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b0, g, o);
      chk(o == 1'b0, "R7 no drive after burst read", int'(o), 0);
    end
    end_xfer();
    for (int i = 0; i < NREG; i++)
      chk(got[8*i +: 8] == exp_bank[i], "R6 burst read byte", int'(got[8*i +: 8]), int'(exp_bank[i]));
  endtask

  task automatic abort_write(input int addr, input logic [7:0] v, input int nbits);
    logic g, o;
    int s0;
    s0 = strobes;
    begin_xfer();
    send_cmd(mk_cmd(addr, 1'b0, 2'b00));
    for (int i = 0; i < nbits; i++) clk_bit(v[i], g, o);
    end_xfer();
    chk(strobes == s0, "R8 partial byte discarded", strobes - s0, 0);
    chk(bank[addr] == exp_bank[addr], "R8 register untouched", int'(bank[addr]), int'(exp_bank[addr]));
  endtask

  task automatic abort_read(input int addr, input int nbits);
    logic g, o;
    begin_xfer();
    send_cmd(mk_cmd(addr, 1'b1, 2'b00));
    for (int i = 0; i < nbits; i++) clk_bit(1'b0, g, o);
    chk(o == 1'b1, "R8 drive before abort", int'(o), 1);
    end_xfer();
  endtask

  task automatic abort_cmd(input logic [7:0] c, input int nbits);
    logic g, o;
    begin_xfer();
    for (int i = 0; i < nbits; i++) clk_bit(c[i], g, o);
    end_xfer();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [63:0] bv;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dio_oe == 1'b0, "R1 oe after reset", int'(dio_oe), 0);
    chk(wr_strobe == 8'h00, "R1 strobe after reset", int'(wr_strobe), 0);
    chk(rd_sel == 3'd0, "R1 rd_sel after reset", int'(rd_sel), 0);

    // directed single accesses, R2 with bits 7:6 set
    single_write(3, 8'hA5, 2'b11, "R3 single write");
    single_read(3, 2'b10, "R4 single read");
    single_write(0, 8'h01, 2'b00, "R3 write reg 0");
    single_write(7, 8'h80, 2'b01, "R2 write reg 7");
    single_read(7, 2'b00, "R2 read reg 7");
    single_read(0, 2'b11, "R4 read reg 0");

    // R9 out-of-range addresses
    single_write(9, 8'hFF, 2'b00, "R9 invalid write");
    single_write(30, 8'h3C, 2'b00, "R9 invalid write 30");
    single_read(8, 2'b00, "R9 invalid read");

    // R5 / R6 / R7 burst
    bv = {$urandom, $urandom};
    burst_write(bv);
    burst_read();

    // R8 aborts
    abort_write(5, 8'h5A, 4);
    abort_write(2, 8'hC3, 7);
    abort_read(4, 3);
    abort_cmd(mk_cmd(6, 1'b0, 2'b00), 4);
    single_write(6, 8'h69, 2'b00, "R8 write after aborted command");
    single_read(4, 2'b00, "R8 read after aborted read");

    // constrained random single accesses
    for (int n = 0; n < 30; n++) begin
      int a;
      logic [7:0] v;
      logic [1:0] hi;
      a  = int'($urandom_range(0, NREG-1));
      v  = 8'($urandom);
      hi = 2'($urandom);
      if ($urandom_range(0, 1) == 0) single_write(a, v, hi, "R3 random write");
      else                           single_read(a, hi, "R4 random read");
    end

    burst_read();

    finished = 1'b1;
    report();
    $finish;
  end

endmodule